// File: doc/BRIEF.md
# Byte-Lane Register Window Adapter

This block connects a little-endian 32-bit I/O slave port to a bank of word-wide register targets that sit inside a 128-byte address window. The port may issue accesses of one, two, three or four bytes at any byte offset. The adapter decodes each access into one of three target regions, a bank of core registers, a bank of DMA registers and a single bus-and-control register, and talks to them through a plain word port that carries a region code and a word index. Target contents and side effects belong to the targets themselves.

Reads fetch the addressed word, shift it down so that the addressed byte lands in lane 0, and zero every lane above the access size. Writes that cover a whole aligned word go straight through. Any other write becomes a read-modify-write: the adapter first fetches the current word over a separate side-effect-free peek strobe, replaces only the addressed lanes, and then writes back the whole word one cycle later while holding the port off. Addresses that fall into holes of the window read as zero and swallow writes.

Top module: `wa_window_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and none of `tgt_rd`, `tgt_peek`, `tgt_wr` is high.
- R2: With W the address with its two low bits cleared, W below 0x40 selects region code 0 (core) with index W>>2, W from 0x40 to 0x5F selects region code 1 (DMA) with index (W-0x40)>>2, and W from 0x70 to 0x73 selects region code 2 (control) with index 0; region code 3 is never presented with a strobe.
- R3: `req_size` holds the byte count minus one (0 to 3). A read returns the target word shifted right by 8 times the low two address bits, with every byte lane at or above the byte count forced to zero.
- R4: A read raises `tgt_rd` in the cycle it is accepted; `rsp_valid` is high with the data in exactly the following cycle and low otherwise.
- R5: A read whose W lies in no region returns zero and raises no target strobe.
- R6: A write of size code 3 at an offset with both low bits zero raises `tgt_wr` with `req_wdata` in the cycle it is accepted, and `req_ready` stays high.
- R7: Any other write raises `tgt_peek` in the cycle it is accepted and `tgt_wr` in the next cycle with a merged word: lanes from the byte offset up to offset plus size code take data bytes 0, 1, ... in order, lanes above 3 are discarded, and every other lane keeps the peeked value.
- R8: For the peek of a merge, W from 0x60 to 0x73 reads the control register and other unmapped W use zero; a write whose W lies in no region raises no `tgt_wr`, so no register changes.
- R9: In the cycle after a merge write is accepted `req_ready` is low; a request presented then is not taken and is accepted in the following cycle.
- R10: The merge fetch never raises `tgt_rd`, so a target's read side effect (in the bench, DMA word 5 losing bits 3:1 on `tgt_rd`) is not triggered by a narrow write; at most one target strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Port request present |
| req_ready | output | 1 | Port can take a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 7 | Byte offset inside the window |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write data, byte 0 in lane 0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Aligned, zero-extended read data |
| tgt_rd | output | 1 | Target read with side effects allowed |
| tgt_peek | output | 1 | Target read without side effects |
| tgt_wr | output | 1 | Target full-word write |
| tgt_region | output | 2 | Region code 0 core, 1 DMA, 2 control |
| tgt_index | output | 4 | Word index inside the region |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32 | Target read data, same cycle as the strobe |

## Verification
Read data and `rsp_valid` are due one edge after the accepting edge, so the bench drives on the falling edge, lets one rising edge pass and samples at the next falling edge. A full write lands in the target at the accepting edge, while a merged write lands one edge later; the bench therefore compares its register model only after the extra cycle and checks `req_ready` low in between. The target strobes are counted per access and compared with the count the address and direction call for.

// File: rtl/wa_pkg.sv
package wa_pkg;
   typedef enum logic [1:0] {
      RGN_CORE = 2'd0,
      RGN_DMA  = 2'd1,
      RGN_CTRL = 2'd2,
      RGN_NONE = 2'd3
   } rgn_e;
endpackage

// File: rtl/wa_decode.sv
module wa_decode
   import wa_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int BYTES      = 4,
   parameter int IDX_W      = 4,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 'h40,
   parameter int DMA_WORDS  = 8,
   parameter int HOLE_LO    = 'h60,
   parameter int CTRL_OFF   = 'h70,
   localparam int OFF_W     = $clog2(BYTES)
) (
   input  logic [ADDR_W-1:0] addr,
   output rgn_e              acc_rgn,
   output logic [IDX_W-1:0]  acc_idx,
   output rgn_e              src_rgn,
   output logic [IDX_W-1:0]  src_idx
);
   localparam int CORE_END = CORE_WORDS * BYTES;
   localparam int DMA_END  = DMA_BASE + DMA_WORDS * BYTES;
   localparam int HOLE_END = CTRL_OFF + BYTES;

   if (DMA_BASE < CORE_END || DMA_BASE % BYTES != 0) begin : g_bad_dma
      $error("wa_decode: DMA bank overlaps core bank or is misaligned");
   end
   if (HOLE_LO < DMA_END || CTRL_OFF < HOLE_LO) begin : g_bad_hole
      $error("wa_decode: control register placement out of order");
   end
   if (HOLE_END > (1 << ADDR_W)) begin : g_bad_win
      $error("wa_decode: control register beyond window");
   end
   if ((1 << IDX_W) < CORE_WORDS || (1 << IDX_W) < DMA_WORDS) begin : g_bad_idx
      $error("wa_decode: index width too small");
   end

   logic [ADDR_W-1:0] word_a;
   int                wa;
   assign word_a = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign wa     = int'(word_a);

   always_comb begin
      acc_rgn = RGN_NONE;
      acc_idx = '0;
      if (wa < CORE_END) begin
         acc_rgn = RGN_CORE;
         acc_idx = IDX_W'(wa >> OFF_W);
      end else if (wa >= DMA_BASE && wa < DMA_END) begin
         acc_rgn = RGN_DMA;
         acc_idx = IDX_W'((wa - DMA_BASE) >> OFF_W);
      end else if (wa == CTRL_OFF) begin
         acc_rgn = RGN_CTRL;
      end
   end

   always_comb begin
      src_rgn = acc_rgn;
      src_idx = acc_idx;
      if (acc_rgn == RGN_NONE && wa >= HOLE_LO && wa < HOLE_END) begin
         src_rgn = RGN_CTRL;
         src_idx = '0;
      end
   end
endmodule

// File: rtl/wa_lane_merge.sv
module wa_lane_merge #(
   parameter int BYTES = 4,
   localparam int OFF_W = $clog2(BYTES),
   localparam int DW    = 8 * BYTES
) (
   input  logic [DW-1:0]    cur,
   input  logic [DW-1:0]    wdata,
   input  logic [OFF_W-1:0] off,
   input  logic [OFF_W-1:0] size,
   output logic [DW-1:0]    merged,
   output logic             full
);
   logic [DW-1:0] lifted;
   int            lo;
   int            hi;

   assign full   = (size == OFF_W'(BYTES - 1)) && (off == '0);
   assign lifted = wdata << {off, 3'b000};
   assign lo     = int'(off);
   assign hi     = int'(off) + int'(size);

   for (genvar j = 0; j < BYTES; j++) begin : g_lane
      logic take;
      assign take            = (j >= lo) && (j <= hi);
      assign merged[8*j +: 8] = take ? lifted[8*j +: 8] : cur[8*j +: 8];
   end
endmodule

// File: rtl/wa_read_align.sv
module wa_read_align #(
   parameter int BYTES   = 4,
   parameter bit RSP_REG = 1'b1,
   localparam int OFF_W  = $clog2(BYTES),
   localparam int DW     = 8 * BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DW-1:0]    word,
   input  logic [OFF_W-1:0] off,
   input  logic [OFF_W-1:0] size,
   output logic             valid,
   output logic [DW-1:0]    data
);
   logic [DW-1:0] shifted;
   logic [DW-1:0] trimmed;

   assign shifted = word >> {off, 3'b000};

   for (genvar j = 0; j < BYTES; j++) begin : g_lane
      assign trimmed[8*j +: 8] = (j <= int'(size)) ? shifted[8*j +: 8] : 8'h00;
   end

   if (RSP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
         end else begin
            valid <= load;
            if (load) data <= trimmed;
         end
      end
   end else begin : g_comb
      assign valid = load;
      assign data  = trimmed;
   end
endmodule

// File: rtl/wa_window_adapter.sv
module wa_window_adapter
   import wa_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 7,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 'h40,
   parameter int DMA_WORDS  = 8,
   parameter int HOLE_LO    = 'h60,
   parameter int CTRL_OFF   = 'h70,
   parameter int IDX_W      = 4,
   parameter bit RSP_REG    = 1'b1,
   localparam int BYTES     = DATA_W / 8,
   localparam int OFF_W     = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [OFF_W-1:0]  req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              tgt_rd,
   output logic              tgt_peek,
   output logic              tgt_wr,
   output logic [1:0]        tgt_region,
   output logic [IDX_W-1:0]  tgt_index,
   output logic [DATA_W-1:0] tgt_wdata,
   input  logic [DATA_W-1:0] tgt_rdata
);
   if (DATA_W % 8 != 0 || BYTES < 2 || (1 << OFF_W) != BYTES) begin : g_bad_w
      $error("wa_window_adapter: data width must be a power-of-two byte count");
   end

   rgn_e              acc_rgn, src_rgn, hold_rgn_q, sel_rgn;
   logic [IDX_W-1:0]  acc_idx, src_idx, hold_idx_q, sel_idx;
   logic [DATA_W-1:0] cur_word, merged, merged_q, rd_word;
   logic [OFF_W-1:0]  off;
   logic              full, merge_q, accept, narrow_wr;

   assign off       = req_addr[OFF_W-1:0];
   assign req_ready = ~merge_q;
   assign accept    = req_valid & ~merge_q;
   assign narrow_wr = accept & req_write & ~full;

   wa_decode #(
      .ADDR_W(ADDR_W), .BYTES(BYTES), .IDX_W(IDX_W),
      .CORE_WORDS(CORE_WORDS), .DMA_BASE(DMA_BASE), .DMA_WORDS(DMA_WORDS),
      .HOLE_LO(HOLE_LO), .CTRL_OFF(CTRL_OFF)
   ) i_decode (
      .addr(req_addr), .acc_rgn(acc_rgn), .acc_idx(acc_idx),
      .src_rgn(src_rgn), .src_idx(src_idx)
   );

   assign cur_word = (src_rgn != RGN_NONE) ? tgt_rdata : '0;

   wa_lane_merge #(.BYTES(BYTES)) i_merge (
      .cur(cur_word), .wdata(req_wdata), .off(off), .size(req_size),
      .merged(merged), .full(full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         merge_q    <= 1'b0;
         hold_rgn_q <= RGN_NONE;
         hold_idx_q <= '0;
         merged_q   <= '0;
      end else begin
         merge_q <= narrow_wr;
         if (narrow_wr) begin
            hold_rgn_q <= acc_rgn;
            hold_idx_q <= acc_idx;
            merged_q   <= merged;
         end
      end
   end

   always_comb begin
      if (merge_q) begin
         sel_rgn = hold_rgn_q;
         sel_idx = hold_idx_q;
      end else if (req_write && !full) begin
         sel_rgn = src_rgn;
         sel_idx = src_idx;
      end else begin
         sel_rgn = acc_rgn;
         sel_idx = acc_idx;
      end
   end

   assign tgt_region = sel_rgn;
   assign tgt_index  = sel_idx;
   assign tgt_rd     = accept & ~req_write & (acc_rgn != RGN_NONE);
   assign tgt_peek   = narrow_wr & (src_rgn != RGN_NONE);
   assign tgt_wr     = merge_q ? (hold_rgn_q != RGN_NONE)
                               : (accept & req_write & full & (acc_rgn != RGN_NONE));
   assign tgt_wdata  = merge_q ? merged_q : req_wdata;

   assign rd_word = (acc_rgn != RGN_NONE) ? tgt_rdata : '0;

   wa_read_align #(.BYTES(BYTES), .RSP_REG(RSP_REG)) i_align (
      .clk(clk), .rst_n(rst_n), .load(accept & ~req_write),
      .word(rd_word), .off(off), .size(req_size),
      .valid(rsp_valid), .data(rsp_rdata)
   );
endmodule

// File: rtl/wa_window_adapter_chk.sv
module wa_window_adapter_chk #(
   parameter int ADDR_W  = 7,
   parameter int OFF_W   = 2,
   parameter bit RSP_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [OFF_W-1:0]  req_size,
   input logic              rsp_valid,
   input logic              tgt_rd,
   input logic              tgt_peek,
   input logic              tgt_wr,
   input logic [1:0]        tgt_region
);
   logic whole_word;
   assign whole_word = (req_size == {OFF_W{1'b1}}) && (req_addr[OFF_W-1:0] == '0);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tgt_rd, tgt_peek, tgt_wr})); // R10
   AST_NO_READ_IN_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> (!tgt_rd && !tgt_peek)); // R10
   AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rd || tgt_peek || tgt_wr) |-> (tgt_region != 2'd3)); // R2
   AST_STALL_AFTER_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && !whole_word) |=> !req_ready); // R9
   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready); // R9
   AST_FULL_WRITE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && whole_word) |=> req_ready); // R6

   if (RSP_REG) begin : g_rsp
      AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> $past(req_valid && req_ready && !req_write)); // R4
   end
endmodule

bind wa_window_adapter wa_window_adapter_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .RSP_REG(RSP_REG)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
   .rsp_valid(rsp_valid), .tgt_rd(tgt_rd), .tgt_peek(tgt_peek),
   .tgt_wr(tgt_wr), .tgt_region(tgt_region)
);

// File: tb/test_wa_window_adapter.sv
module test_wa_window_adapter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, tgt_rd, tgt_peek, tgt_wr;
   logic [31:0] rsp_rdata, tgt_wdata, tgt_rdata;
   logic [1:0]  tgt_region;
   logic [3:0]  tgt_index;

   int checks = 0, failures = 0, rd_cnt = 0, wr_cnt = 0, tslot;
   logic [31:0] tmem [26];
   logic [31:0] exp_mem [25];

   always #5 clk = ~clk;

   wa_window_adapter i_wa_window_adapter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .tgt_rd(tgt_rd), .tgt_peek(tgt_peek), .tgt_wr(tgt_wr),
      .tgt_region(tgt_region), .tgt_index(tgt_index),
      .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
   );

   function automatic logic [31:0] init_val(int i);
      return (32'h1357_9BDF * (i + 1)) ^ 32'h0000_000E;
   endfunction

   // target model: region 0 -> slots 0..15, 1 -> 16..23, 2 -> 24
   always_comb begin
      case (tgt_region)
         2'd0: tslot = int'(tgt_index);
         2'd1: tslot = (tgt_index < 4'd8) ? 16 + int'(tgt_index) : 25;
         2'd2: tslot = 24;
         default: tslot = 25;
      endcase
      tgt_rdata = (tslot < 25) ? tmem[tslot] : 32'h0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 26; i++) tmem[i] <= init_val(i);
      end else begin
         if (tgt_wr) tmem[tslot] <= tgt_wdata;
         if (tgt_rd && tslot == 21) tmem[21] <= tmem[21] & ~32'h0000_000E;
      end
   end

   always_ff @(posedge clk) begin
      if (tgt_rd) rd_cnt <= rd_cnt + 1;
      if (tgt_wr) wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic int slot_of(int a);
      int w = a & ~3;
      if (w < 'h40) return w >> 2;
      if (w < 'h60) return 16 + ((w - 'h40) >> 2);
      if (w == 'h70) return 24;
      return -1;
   endfunction

   function automatic logic [31:0] exp_read(int a, int sz);
      int s = slot_of(a);
      logic [31:0] w;
      if (s < 0) return 32'h0;
      w = exp_mem[s] >> (8 * (a & 3));
      for (int b = 0; b < 4; b++) if (b > sz) w[8*b +: 8] = 8'h00;
      return w;
   endfunction

   function automatic logic [31:0] exp_merge(int a, int sz, logic [31:0] d);
      int s = slot_of(a);
      logic [31:0] cur;
      if (s >= 0) cur = exp_mem[s];
      else if ((a & ~3) >= 'h60 && (a & ~3) < 'h74) cur = exp_mem[24];
      else cur = 32'h0;
      for (int i = 0; i <= sz; i++)
         if ((a & 3) + i < 4) cur[8*((a & 3) + i) +: 8] = d[8*i +: 8];
      return cur;
   endfunction

   task automatic cmp_mem(string tag);
      bit ok = 1'b1;
      int bad = 0;
      for (int i = 0; i < 25; i++)
         if (ok && tmem[i] !== exp_mem[i]) begin ok = 1'b0; bad = i; end
      chk(ok, tag, tmem[bad], exp_mem[bad]);
   endtask

   task automatic access(bit wr, int a, int sz, logic [31:0] d, string tag);
      int rd0 = rd_cnt, wr0 = wr_cnt, s = slot_of(a);
      bit whole = (sz == 3) && ((a & 3) == 0);
      logic [31:0] ev;
      ev = wr ? (whole ? d : exp_merge(a, sz, d)) : exp_read(a, sz);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 7'(a);
      req_size = 2'(sz); req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!wr) begin
         chk(rsp_valid === 1'b1 && rsp_rdata === ev, {tag, " R3 R4 read data"}, rsp_rdata, ev);
         if (s == 21) exp_mem[21] = exp_mem[21] & ~32'h0000_000E;
      end else if (!whole) begin
         chk(req_ready === 1'b0, {tag, " R9 stall in merge"}, 32'(req_ready), 32'h0);
         @(negedge clk);
      end else begin
         chk(req_ready === 1'b1 && rsp_valid === 1'b0, {tag, " R6 no stall"},
             32'(req_ready), 32'h1);
      end
      if (wr && s >= 0) exp_mem[s] = ev;
      chk(rd_cnt - rd0 == ((!wr && s >= 0) ? 1 : 0), {tag, " R5 R10 read strobes"},
          32'(rd_cnt - rd0), 32'((!wr && s >= 0) ? 1 : 0));
      chk(wr_cnt - wr0 == ((wr && s >= 0) ? 1 : 0), {tag, " R8 write strobes"},
          32'(wr_cnt - wr0), 32'((wr && s >= 0) ? 1 : 0));
      cmp_mem({tag, " R7 registers"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 25; i++) exp_mem[i] = init_val(i);
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && !tgt_rd && !tgt_peek && !tgt_wr,
          "R1 reset state", {29'h0, req_ready, rsp_valid, tgt_wr}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && !tgt_wr,
          "R1 after reset", {30'h0, req_ready, rsp_valid}, 32'h2);

      // R2 R3 R4: region decode and alignment
      access(0, 'h08, 3, 0, "core word");
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R4 single-cycle response", 32'(rsp_valid), 32'h0);
      access(0, 'h0B, 0, 0, "core byte3");
      access(0, 'h0A, 1, 0, "core half");
      access(0, 'h02, 3, 0, "R3 word past lane3");
      access(0, 'h48, 3, 0, "R2 dma word");
      access(0, 'h70, 3, 0, "R2 ctrl word");
      access(0, 'h72, 1, 0, "R2 ctrl upper half");
      // R5 holes
      access(0, 'h60, 3, 0, "R5 hole 0x60");
      access(0, 'h7C, 0, 0, "R5 hole 0x7C");
      // R6 full write, R7 merges
      access(1, 'h44, 3, 32'hCAFE_F00D, "R6 full dma write");
      access(1, 'h13, 1, 32'h0000_BBAA, "R7 half at lane3");
      access(1, 'h21, 2, 32'h0033_2211, "R7 three bytes");
      access(1, 'h30, 3, 32'h8899_AABB, "R6 word again");
      // R8 control merge and dropped writes
      access(1, 'h71, 0, 32'h0000_005A, "R8 ctrl byte");
      access(1, 'h61, 0, 32'h0000_00C3, "R8 dropped hole");
      access(1, 'h7A, 1, 32'h0000_1234, "R8 dropped tail");
      access(1, 'h78, 3, 32'h1234_5678, "R8 dropped full");
      // R10 merge into side-effect word keeps status bits
      access(1, 'h57, 0, 32'h0000_00EE, "R10 peek dma5");
      access(0, 'h54, 3, 0, "R10 read dma5");
      access(0, 'h54, 0, 0, "R10 dma5 after clear");

      // R9 request held during merge write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h05; req_size = 2'd0;
      req_wdata = 32'h0000_00AB;
      @(negedge clk);
      chk(req_ready === 1'b0 && tgt_wr === 1'b1, "R9 stall with write",
          {30'h0, req_ready, tgt_wr}, 32'h1);
      exp_mem[1][15:8] = 8'hAB;
      req_write = 1'b0; req_addr = 7'h04; req_size = 2'd3;
      @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R9 not taken during stall",
          {30'h0, req_ready, rsp_valid}, 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid === 1'b1 && rsp_rdata === exp_mem[1], "R9 held read", rsp_rdata, exp_mem[1]);

      // constrained random traffic
      void'($urandom(32'd7321));
      for (int n = 0; n < 400; n++) begin
         int a = int'($urandom % 128);
         int sz = int'($urandom % 4);
         bit wr = $urandom % 2;
         if (n % 5 == 0) begin sz = 3; a = a & ~3; end
         access(wr, a, sz, $urandom, "random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule